// File: doc/BRIEF.md
# Ping-Pong Endpoint Buffer with Automatic NAK

This block holds the packet data of one bulk or interrupt endpoint in two banks of `BANK_BYTES` bytes each. One side produces packets and the other consumes them. Because there are two banks, the producer can fill one bank while the consumer drains the other in the same clock cycles. A two-bit occupancy state records how many banks hold a committed packet. Banks are handed over strictly in turn.

A parameter selects the direction. With `IS_IN = 1`, the CPU port produces packets. The CPU writes the bytes and then commits the bank by writing its byte count. The bus side reads the bank and ends the transfer with a done pulse that carries an ok flag: an acknowledged transfer frees the bank, and a failed one rewinds it so the packet can be sent again. With `IS_IN = 0`, the bus side produces packets. A good packet commits the bank with the number of bytes received, a bad packet is discarded, and the CPU reads the bank and releases it.

The occupancy state drives the NAK decision for the bus side without any other logic in between. The same state drives a single CPU-side availability flag, which can be used as an interrupt request.

Top module: `pingpong_ep_buf`

## Requirements
- R1: After reset both banks are empty and all read data and count outputs are 0. In the IN direction `usbNak`=1 and `cpuAvail`=1; in the OUT direction `usbNak`=0 and `cpuAvail`=0.
- R2: The consumer reads the bytes of a bank in the order the producer wrote them. The read data port shows the current byte combinationally, and a read strobe steps to the next byte. The producer may fill one bank in the same cycles in which the consumer drains the other.
- R3: At most two banks are ever committed. While both are committed, producer byte writes and producer commits have no effect. In the IN direction these are `cpuWrEn` and `cpuCommit`; in the OUT direction they are `usbWrEn` and `usbDone`.
- R4: Committed banks are consumed in the order they were committed.
- R5: In the IN direction, `usbNak` is 1 exactly when no bank is committed. `usbCount` shows the byte count of the oldest committed bank, or 0 when there is none.
- R6: In the IN direction, `usbDone` with `usbOk`=0 keeps the bank committed, keeps its count and rewinds reading to its first byte. `usbDone` with `usbOk`=1 frees the bank.
- R7: In the OUT direction, `usbNak` is 1 exactly when both banks hold packets the CPU has not released. `usbDone` with `usbOk`=1 commits the bank with the number of bytes written. `usbDone` with `usbOk`=0 discards the written bytes, so the next packet starts again at byte 0 of the same bank.
- R8: In the OUT direction, `cpuCount` shows the byte count of the oldest received packet, or 0 when there is none. `cpuRelease` frees that bank.
- R9: In the IN direction, `cpuAvail` is 1 when a bank is free to fill. In the OUT direction, it is 1 when a received packet is waiting.
- R10: A read strobe at or beyond the committed count does not advance the read position, and the read data port shows 0 there.
- R11: In the IN direction, a committed count above `BANK_BYTES` is stored as `BANK_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrEn | input | 1 | CPU byte write strobe (IN direction) |
| cpuWrData | input | 8 | CPU write byte |
| cpuCommit | input | 1 | CPU commit of the bank being filled (IN direction) |
| cpuCommitCnt | input | CNT_W | Byte count for the commit |
| cpuRdEn | input | 1 | CPU read strobe (OUT direction) |
| cpuRdData | output | 8 | Current CPU read byte |
| cpuRelease | input | 1 | CPU release of the oldest received bank (OUT direction) |
| cpuCount | output | CNT_W | Count of the oldest received packet (OUT direction) |
| cpuAvail | output | 1 | Buffer-available flag for an interrupt request |
| usbWrEn | input | 1 | Bus byte write strobe (OUT direction) |
| usbWrData | input | 8 | Bus write byte |
| usbRdEn | input | 1 | Bus read strobe (IN direction) |
| usbRdData | output | 8 | Current bus read byte |
| usbDone | input | 1 | Bus transfer finished |
| usbOk | input | 1 | Qualifies usbDone: 1 = acknowledged or good, 0 = failed |
| usbCount | output | CNT_W | Count of the bank to send (IN direction) |
| usbNak | output | 1 | Answer the next bus request with NAK |

## Verification
The bench runs packets of 0, 1, 64 and random lengths through both directions, and in one phase fills a bank while the other bank is being drained. A design that wrapped the occupancy state would accept writes while both banks are full. That would shift the bytes of a later packet or change the count being served. A failed bus transfer is checked for its rewind: a design that freed the bank or left the read position in place would show the wrong count or a later byte. The bench also checks a bad received packet followed by a good one, reads past the end of a packet, and a commit count above the bank size.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
  // Strobes from the control into the datapath, already gated by occupancy.
  typedef struct packed {
    logic prodWr;      // store one byte into the producer bank
    logic prodCommit;  // latch the count, clear the write pointer
    logic prodDrop;    // clear the write pointer, keep the old count
    logic prodBank;    // bank the producer owns
    logic consRd;      // step the read pointer
    logic consNext;    // bank consumed, clear the read pointer
    logic consRewind;  // retry, clear the read pointer
    logic consBank;    // bank the consumer owns
    logic consValid;   // the consumer bank holds a committed packet
  } epbStrobe_t;
endpackage

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl
  import epbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       prodWrReq,
  input  logic       prodCommitReq,
  input  logic       prodDropReq,
  input  logic       consRdReq,
  input  logic       consDoneReq,
  input  logic       consFailReq,
  output epbStrobe_t stb,
  output logic       prodAvail,
  output logic       consAvail
);
  typedef enum logic [1:0] {OCC_NONE = 2'd0, OCC_ONE = 2'd1, OCC_TWO = 2'd2} occ_t;

  occ_t occ, occNext;
  logic prodSel, consSel;
  logic doWr, doCommit, doDrop, doRd, doDone, doFail;

  assign prodAvail = (occ != OCC_TWO);
  assign consAvail = (occ != OCC_NONE);

  // A commit or drop takes precedence over a byte strobe in the same cycle.
  assign doCommit = prodCommitReq & prodAvail;
  assign doDrop   = prodDropReq & prodAvail & ~prodCommitReq;
  assign doWr     = prodWrReq & prodAvail & ~prodCommitReq & ~prodDropReq;
  assign doDone   = consDoneReq & consAvail;
  assign doFail   = consFailReq & consAvail & ~consDoneReq;
  assign doRd     = consRdReq & consAvail & ~consDoneReq & ~consFailReq;

  always_comb begin
    occNext = occ;
    unique case ({doCommit, doDone})
      2'b10: begin
        if (occ == OCC_NONE) occNext = OCC_ONE;
        else                 occNext = OCC_TWO;
      end
      2'b01: begin
        if (occ == OCC_TWO) occNext = OCC_ONE;
        else                occNext = OCC_NONE;
      end
      default: occNext = occ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ     <= OCC_NONE;
      prodSel <= 1'b0;
      consSel <= 1'b0;
    end else begin
      occ <= occNext;
      if (doCommit) prodSel <= ~prodSel;
      if (doDone)   consSel <= ~consSel;
    end
  end

  always_comb begin
    stb.prodWr     = doWr;
    stb.prodCommit = doCommit;
    stb.prodDrop   = doDrop;
    stb.prodBank   = prodSel;
    stb.consRd     = doRd;
    stb.consNext   = doDone;
    stb.consRewind = doFail;
    stb.consBank   = consSel;
    stb.consValid  = consAvail;
  end

  // R3: a full buffer stays full until the consumer frees a bank.
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_TWO && !doDone) |=> occ == OCC_TWO);
  // R4: each commit hands the producer the other bank.
  p_commit_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    doCommit |=> prodSel != $past(prodSel));
  // R4: each completion moves the consumer to the other bank.
  p_done_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    doDone |=> consSel != $past(consSel));
  // R6: a failed transfer leaves the occupancy and the consumer bank unchanged.
  p_fail_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doFail && !doCommit) |=> (occ == $past(occ)) && (consSel == $past(consSel)));
  // R5: an empty buffer stays empty until something is committed.
  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_NONE && !doCommit) |=> occ == OCC_NONE);
endmodule

// File: rtl/epbuf_data.sv
module epbuf_data
  import epbuf_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter bit COUNT_FROM_WRPTR = 1'b0,
  localparam int CNT_W = $clog2(BANK_BYTES + 1),
  localparam int ADDR_W = $clog2(BANK_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  epbStrobe_t       stb,
  input  logic [7:0]       wrData,
  input  logic [CNT_W-1:0] commitCnt,
  output logic [7:0]       rdData,
  output logic [CNT_W-1:0] consCount
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BANK_BYTES);

  logic [CNT_W-1:0] wrPtr, rdPtr, newCnt, satCnt, curCnt;
  logic [CNT_W-1:0] bankCnt [2];
  logic [7:0]       bankRd  [2];
  logic             canRd;

  assign satCnt = (commitCnt > FULL_CNT) ? FULL_CNT : commitCnt;
  assign newCnt = COUNT_FROM_WRPTR ? wrPtr : satCnt;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0]       store [BANK_BYTES];
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (stb.prodWr && (stb.prodBank == 1'(b)) && (wrPtr < FULL_CNT))
        store[wrPtr[ADDR_W-1:0]] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cnt <= '0;
      else if (stb.prodCommit && (stb.prodBank == 1'(b))) cnt <= newCnt;
    end

    assign bankCnt[b] = cnt;
    assign bankRd[b]  = store[rdPtr[ADDR_W-1:0]];
  end

  assign curCnt    = bankCnt[stb.consBank];
  assign canRd     = stb.consValid && (rdPtr < curCnt);
  assign rdData    = canRd ? bankRd[stb.consBank] : 8'd0;
  assign consCount = stb.consValid ? curCnt : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.prodCommit || stb.prodDrop)        wrPtr <= '0;
      else if (stb.prodWr && (wrPtr < FULL_CNT)) wrPtr <= wrPtr + 1'b1;

      if (stb.consNext || stb.consRewind) rdPtr <= '0;
      else if (stb.consRd && canRd)       rdPtr <= rdPtr + 1'b1;
    end
  end

  // R2: the write pointer never passes the end of a bank.
  p_wr_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= FULL_CNT);
  // R10: the read pointer never passes the committed count.
  p_rd_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.consValid |-> rdPtr <= curCnt);
  // R10: a read strobe at the end of a packet does not move the pointer.
  p_rd_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.consRd && rdPtr == curCnt && !stb.consNext && !stb.consRewind)
      |=> rdPtr == $past(rdPtr));
  // R7: a dropped packet restarts the next one at byte zero.
  p_drop_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.prodDrop |=> wrPtr == '0);
  // R11: a stored count never exceeds the bank size.
  p_sat_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.prodCommit |=> bankCnt[$past(stb.prodBank)] <= FULL_CNT);
endmodule

// File: rtl/pingpong_ep_buf.sv
module pingpong_ep_buf
  import epbuf_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter bit IS_IN = 1'b1,
  localparam int CNT_W = $clog2(BANK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic [7:0]       cpuWrData,
  input  logic             cpuCommit,
  input  logic [CNT_W-1:0] cpuCommitCnt,
  input  logic             cpuRdEn,
  output logic [7:0]       cpuRdData,
  input  logic             cpuRelease,
  output logic [CNT_W-1:0] cpuCount,
  output logic             cpuAvail,
  input  logic             usbWrEn,
  input  logic [7:0]       usbWrData,
  input  logic             usbRdEn,
  output logic [7:0]       usbRdData,
  input  logic             usbDone,
  input  logic             usbOk,
  output logic [CNT_W-1:0] usbCount,
  output logic             usbNak
);
  epbStrobe_t       stb;
  logic             prodAvail, consAvail;
  logic [7:0]       rdData, prodData;
  logic [CNT_W-1:0] consCount;

  // Map the two ports onto producer and consumer roles.
  logic prodWrReq, prodCommitReq, prodDropReq, consRdReq, consDoneReq, consFailReq;

  assign prodWrReq     = IS_IN ? cpuWrEn   : usbWrEn;
  assign prodCommitReq = IS_IN ? cpuCommit : (usbDone & usbOk);
  assign prodDropReq   = IS_IN ? 1'b0      : (usbDone & ~usbOk);
  assign consRdReq     = IS_IN ? usbRdEn   : cpuRdEn;
  assign consDoneReq   = IS_IN ? (usbDone & usbOk)  : cpuRelease;
  assign consFailReq   = IS_IN ? (usbDone & ~usbOk) : 1'b0;
  assign prodData      = IS_IN ? cpuWrData : usbWrData;

  epbuf_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .prodWrReq    (prodWrReq),
    .prodCommitReq(prodCommitReq),
    .prodDropReq  (prodDropReq),
    .consRdReq    (consRdReq),
    .consDoneReq  (consDoneReq),
    .consFailReq  (consFailReq),
    .stb          (stb),
    .prodAvail    (prodAvail),
    .consAvail    (consAvail)
  );

  epbuf_data #(
    .BANK_BYTES      (BANK_BYTES),
    .COUNT_FROM_WRPTR(!IS_IN)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (prodData),
    .commitCnt(cpuCommitCnt),
    .rdData   (rdData),
    .consCount(consCount)
  );

  assign cpuRdData = IS_IN ? 8'd0 : rdData;
  assign usbRdData = IS_IN ? rdData : 8'd0;
  assign cpuCount  = IS_IN ? '0 : consCount;
  assign usbCount  = IS_IN ? consCount : '0;
  assign usbNak    = IS_IN ? ~consAvail : ~prodAvail;
  assign cpuAvail  = IS_IN ? prodAvail : consAvail;
endmodule

// File: tb/pingpong_ep_buf_test.sv
`timescale 1ns/1ps
module pingpong_ep_buf_test;
  localparam int BB = 64;
  localparam int CW = $clog2(BB + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rstN;

  // IN-direction instance signals
  logic iWrEn, iCommit, iRdEn, iRel, iUWrEn, iURdEn, iUDone, iUOk, iAvail, iNak;
  logic [7:0] iWrData, iUWrData, iRdData, iURdData;
  logic [CW-1:0] iCommitCnt, iCount, iUCount;
  // OUT-direction instance signals
  logic oWrEn, oCommit, oRdEn, oRel, oUWrEn, oURdEn, oUDone, oUOk, oAvail, oNak;
  logic [7:0] oWrData, oUWrData, oRdData, oURdData;
  logic [CW-1:0] oCommitCnt, oCount, oUCount;

  pingpong_ep_buf #(.BANK_BYTES(BB), .IS_IN(1'b1)) uut (
    .clk(clk), .rstN(rstN), .cpuWrEn(iWrEn), .cpuWrData(iWrData), .cpuCommit(iCommit),
    .cpuCommitCnt(iCommitCnt), .cpuRdEn(iRdEn), .cpuRdData(iRdData), .cpuRelease(iRel),
    .cpuCount(iCount), .cpuAvail(iAvail), .usbWrEn(iUWrEn), .usbWrData(iUWrData),
    .usbRdEn(iURdEn), .usbRdData(iURdData), .usbDone(iUDone), .usbOk(iUOk),
    .usbCount(iUCount), .usbNak(iNak));

  pingpong_ep_buf #(.BANK_BYTES(BB), .IS_IN(1'b0)) uutOut (
    .clk(clk), .rstN(rstN), .cpuWrEn(oWrEn), .cpuWrData(oWrData), .cpuCommit(oCommit),
    .cpuCommitCnt(oCommitCnt), .cpuRdEn(oRdEn), .cpuRdData(oRdData), .cpuRelease(oRel),
    .cpuCount(oCount), .cpuAvail(oAvail), .usbWrEn(oUWrEn), .usbWrData(oUWrData),
    .usbRdEn(oURdEn), .usbRdData(oURdData), .usbDone(oUDone), .usbOk(oUOk),
    .usbCount(oUCount), .usbNak(oNak));

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] pk [2][BB];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // IN direction helpers
  task automatic inFill(input int slot, input int n, input int cc);
    for (int i = 0; i < n; i++) begin
      pk[slot][i] = 8'($urandom);
      iWrData = pk[slot][i];
      iWrEn = 1'b1;
      tick();
    end
    iWrEn = 1'b0;
    iCommitCnt = CW'(cc);
    iCommit = 1'b1;
    tick();
    iCommit = 1'b0;
  endtask

  task automatic inRead(input int slot, input int n, input string req);
    iURdEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk(req, int'(iURdData), int'(pk[slot][i]));
      tick();
    end
    iURdEn = 1'b0;
  endtask

  task automatic inDone(input bit ok);
    iUDone = 1'b1;
    iUOk = ok;
    tick();
    iUDone = 1'b0;
    iUOk = 1'b0;
  endtask

  // OUT direction helpers; slot < 0 sends bytes the bench does not keep
  task automatic outRecv(input int slot, input int n, input bit ok);
    for (int i = 0; i < n; i++) begin
      oUWrData = 8'($urandom);
      if (slot >= 0) pk[slot][i] = oUWrData;
      oUWrEn = 1'b1;
      tick();
    end
    oUWrEn = 1'b0;
    oUDone = 1'b1;
    oUOk = ok;
    tick();
    oUDone = 1'b0;
    oUOk = 1'b0;
  endtask

  task automatic outRead(input int slot, input int n, input string req);
    oRdEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk(req, int'(oRdData), int'(pk[slot][i]));
      tick();
    end
    oRdEn = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a, b, m, k;
    {iWrEn, iCommit, iRdEn, iRel, iUWrEn, iURdEn, iUDone, iUOk} = '0;
    {oWrEn, oCommit, oRdEn, oRel, oUWrEn, oURdEn, oUDone, oUOk} = '0;
    iWrData = '0; iUWrData = '0; iCommitCnt = '0;
    oWrData = '0; oUWrData = '0; oCommitCnt = '0;
    void'($urandom(32'h00C0FFEE));
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();

    // R1 reset state of both directions
    chk("R1 IN nak", int'(iNak), 1);
    chk("R1 IN avail", int'(iAvail), 1);
    chk("R1 IN count", int'(iUCount), 0);
    chk("R1 IN data", int'(iURdData), 0);
    chk("R1 OUT nak", int'(oNak), 0);
    chk("R1 OUT avail", int'(oAvail), 0);
    chk("R1 OUT count", int'(oCount), 0);
    chk("R1 OUT data", int'(oRdData), 0);

    // IN direction rounds
    for (int r = 0; r < 8; r++) begin
      a = (r == 0) ? 0 : (r == 1) ? BB : int'($urandom % (BB + 1));
      b = (r == 0) ? BB : (r == 1) ? 1 : int'($urandom % (BB + 1));
      inFill(0, a, a);
      chk("R5 nak low with a committed bank", int'(iNak), 0);
      chk("R5 count of committed bank", int'(iUCount), a);
      // R2 concurrent fill of one bank and drain of the other
      m = (a > b) ? a : b;
      for (int j = 0; j < m; j++) begin
        iWrEn = (j < b);
        if (j < b) begin
          pk[1][j] = 8'($urandom);
          iWrData = pk[1][j];
        end
        iURdEn = (j < a);
        if (j < a) chk("R2 concurrent read", int'(iURdData), int'(pk[0][j]));
        tick();
      end
      iWrEn = 1'b0;
      iURdEn = 1'b0;
      chk("R10 data zero past count", int'(iURdData), 0);
      iURdEn = 1'b1;
      tick();
      iURdEn = 1'b0;
      chk("R10 extra read stays zero", int'(iURdData), 0);
      iCommitCnt = CW'(b);
      iCommit = 1'b1;
      tick();
      iCommit = 1'b0;
      chk("R9 IN avail low when both committed", int'(iAvail), 0);
      // R3 write and commit while full must be ignored
      iWrData = 8'hEE; iWrEn = 1'b1; iCommit = 1'b1; iCommitCnt = CW'(5);
      tick();
      iWrEn = 1'b0; iCommit = 1'b0;
      chk("R3 still full", int'(iAvail), 0);
      chk("R3 count unchanged when full", int'(iUCount), a);
      inDone(1'b1);
      chk("R4 second bank served next", int'(iUCount), b);
      chk("R9 IN avail after free", int'(iAvail), 1);
      // R6 failed send then retry
      k = minI(b, 2);
      inRead(1, k, "R2 partial read");
      inDone(1'b0);
      chk("R6 count kept after failure", int'(iUCount), b);
      chk("R6 rewound to first byte", int'(iURdData), (b > 0) ? int'(pk[1][0]) : 0);
      chk("R5 nak stays low after failure", int'(iNak), 0);
      inRead(1, b, "R6 retry data");
      inDone(1'b1);
      chk("R5 nak when empty", int'(iNak), 1);
      chk("R5 count zero when empty", int'(iUCount), 0);
    end

    // R11 oversize commit count
    inFill(0, BB, 100);
    chk("R11 count saturated", int'(iUCount), BB);
    inRead(0, BB, "R11 data");
    inDone(1'b1);

    // OUT direction rounds
    for (int r = 0; r < 8; r++) begin
      a = (r == 0) ? 0 : (r == 1) ? BB : int'($urandom % (BB + 1));
      b = (r == 0) ? BB : (r == 1) ? 1 : int'($urandom % (BB + 1));
      outRecv(0, a, 1'b1);
      chk("R8 count of received packet", int'(oCount), a);
      chk("R9 OUT avail with packet", int'(oAvail), 1);
      chk("R7 nak low with one bank free", int'(oNak), 0);
      outRecv(-1, 1 + int'($urandom % BB), 1'b0);
      chk("R7 bad packet discarded", int'(oCount), a);
      chk("R7 nak low after bad packet", int'(oNak), 0);
      outRecv(1, b, 1'b1);
      chk("R7 nak when both full", int'(oNak), 1);
      outRecv(-1, 3, 1'b1);
      chk("R3 write while full ignored", int'(oNak), 1);
      chk("R3 count unchanged when full", int'(oCount), a);
      outRead(0, a, "R2 OUT data");
      chk("R10 OUT data zero past count", int'(oRdData), 0);
      oRel = 1'b1;
      tick();
      oRel = 1'b0;
      chk("R4 second packet next", int'(oCount), b);
      chk("R7 nak low after release", int'(oNak), 0);
      outRead(1, b, "R7 packet after discard");
      oRel = 1'b1;
      tick();
      oRel = 1'b0;
      chk("R9 OUT avail low when empty", int'(oAvail), 0);
      chk("R8 count zero when empty", int'(oCount), 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule